// File: doc/BRIEF.md
# Single-Wire Bus ROM Command and Search Responder

This block is the device-side identity layer of a single-wire, open-drain serial bus slave. It holds a 64-bit identity built from an 8-bit family byte, a 48-bit serial number and an 8-bit check byte that it computes from the other 56 bits. After every bus reset it decodes one 8-bit ROM command from the master. It then runs the matching flow: identity read-out, addressed match, skip, search, or alarm-conditioned search.

The block never sees analog slot timing. A slot engine in front of it reports three kinds of event. A strobe carries a bit written by the master. A strobe marks a read slot, and the block places the bit it wants to send on `txBit`; a 1 means the line is left released. A third strobe marks a bus reset. When a ROM flow completes, the block emits a one-cycle `selected` pulse that hands the bus to the memory-command layer. A device that is deselected, or that never reached selection, keeps the line released until the next bus reset.

Top module: `owRomResponder`

## Requirements
- R1: The identity is, from bit 0 upward, the family byte (default 10h), the 48-bit serial number, and a check byte. The check byte is computed over the low 56 bits, taken bit 0 first, with the polynomial x^8+x^5+x^4+1 in reflected form, starting from zero. Feeding all 64 identity bits through the same check yields zero.
- R2: After a bus reset the next 8 written bits form a command byte, least significant bit first. The codes are 33h read, 55h match, CCh skip, F0h search and ECh alarm search.
- R3: After a read command, successive read slots return identity bits 0 through 63 in order. A `selected` pulse follows the 64th slot.
- R4: After a match command, 64 written bits are compared with identity bits 0 through 63. If all agree, `selected` pulses after the last bit. On any disagreement the device goes silent until a bus reset and never pulses `selected`.
- R5: A skip command pulses `selected` in the cycle after the strobe of the 8th command bit.
- R6: In a search, each bit position takes three slots: a read returning the identity bit, a read returning its complement, then a written bit. If the written bit differs from the identity bit, the device goes silent until a bus reset. If all 64 positions agree, `selected` pulses.
- R7: An alarm search behaves as R6 when `alarmFlag` is high while the 8th command bit is taken. Otherwise the device goes silent until a bus reset.
- R8: `selected` is high for exactly one cycle. It is raised only at the end of a successful ROM flow. Once the device is selected, further slots produce no further pulse before the next bus reset.
- R9: A bus reset aborts any flow at any point, and the next 8 written bits are decoded as a fresh ROM command.
- R10: An unrecognised command code makes the device silent until a bus reset.
- R11: Whenever the device is not sending an identity bit, `txBit` is 1. This covers the time after `rstN` before the first bus reset, command reception, match, the silent state and the selected state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReset | input | 1 | One-cycle strobe: bus reset detected |
| rxValid | input | 1 | One-cycle strobe: master wrote `rxBit` |
| rxBit | input | 1 | Bit written by the master |
| txReq | input | 1 | One-cycle strobe: read slot consumes `txBit` |
| alarmFlag | input | 1 | Alarm condition from the last measurement |
| txBit | output | 1 | Bit to send in the next read slot (1 = released) |
| selected | output | 1 | One-cycle pulse: ROM flow completed |

## Verification
The match and search flows are each driven twice. One run uses the exact identity, which must end in a selection. The other run departs from the identity at a single position, which separates completing from dropping out, and the read slots that follow must come back released. The read-out is checked bit by bit against an identity and check byte that the bench computes itself. Alarm search is run with the flag low and with it high, which separates silence from a full search. Resets placed partway through a command byte and partway through a match show that an abort recovers, and an unknown code shows that the device stays idle until reset.

// File: rtl/owRomPkg.sv
package owRomPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SRCH,
    ST_GRANT
  } romState_t;

  typedef struct packed {
    logic cmdShift;
    logic cntClr;
    logic cntInc;
  } dpCtl_t;

  localparam logic [7:0] CMD_READ   = 8'h33;
  localparam logic [7:0] CMD_MATCH  = 8'h55;
  localparam logic [7:0] CMD_SKIP   = 8'hCC;
  localparam logic [7:0] CMD_SEARCH = 8'hF0;
  localparam logic [7:0] CMD_ALARM  = 8'hEC;

endpackage

// File: rtl/owRomDatapath.sv
module owRomDatapath
  import owRomPkg::*;
#(
  parameter int FAM_W = 8,
  parameter int SERIAL_W = 48,
  parameter int CRC_W = 8,
  parameter int CMD_W = 8,
  parameter logic [FAM_W-1:0] FAMILY = 8'h10,
  parameter logic [SERIAL_W-1:0] SERIAL = 48'hA1B2_C3D4_E5F6,
  parameter logic [CRC_W-1:0] CRC_POLY_REF = 8'h8C
) (
  input  logic clk,
  input  logic rstN,
  input  dpCtl_t ctl,
  input  logic rxBit,
  output logic idBit,
  output logic cntLast,
  output logic cmdLast,
  output logic [CMD_W-1:0] cmdByte
);
  localparam int BODY_W = FAM_W + SERIAL_W;
  localparam int ID_W = BODY_W + CRC_W;
  localparam int CNT_W = $clog2(ID_W);

  function automatic logic [CRC_W-1:0] crcOf(input logic [BODY_W-1:0] body);
    logic [CRC_W-1:0] acc;
    logic fb;
    acc = '0;
    for (int i = 0; i < BODY_W; i++) begin
      fb = acc[0] ^ body[i];
      acc = acc >> 1;
      if (fb) acc = acc ^ CRC_POLY_REF;
    end
    return acc;
  endfunction

  localparam logic [ID_W-1:0] ROM_ID = {crcOf({SERIAL, FAMILY}), SERIAL, FAMILY};

  logic [CMD_W-1:0] cmdReg;
  logic [CNT_W-1:0] cnt;

  assign cmdByte = {rxBit, cmdReg[CMD_W-1:1]};
  assign idBit   = ROM_ID[cnt];
  assign cntLast = (cnt == CNT_W'(ID_W - 1));
  assign cmdLast = (cnt == CNT_W'(CMD_W - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
      cnt    <= '0;
    end else begin
      if (ctl.cmdShift) cmdReg <= cmdByte;
      if (ctl.cntClr) cnt <= '0;
      else if (ctl.cntInc) cnt <= cnt + 1'b1;
    end
  end

  AST_CMD_LSB_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cmdShift |=> cmdReg[CMD_W-1] == $past(rxBit)); // R2

endmodule

// File: rtl/owRomControl.sv
module owRomControl
  import owRomPkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic busReset,
  input  logic rxValid,
  input  logic rxBit,
  input  logic txReq,
  input  logic alarmFlag,
  input  logic idBit,
  input  logic cntLast,
  input  logic cmdLast,
  input  logic [CMD_W-1:0] cmdByte,
  output dpCtl_t ctl,
  output logic txBit,
  output logic selected
);
  romState_t state, nextState;
  logic [1:0] phase, nextPhase;
  logic grant;

  always_comb begin
    nextState = state;
    nextPhase = phase;
    ctl = '0;
    grant = 1'b0;
    if (busReset) begin
      nextState = ST_CMD;
      nextPhase = 2'd0;
      ctl.cntClr = 1'b1;
    end else begin
      case (state)
        ST_CMD: if (rxValid) begin
          ctl.cmdShift = 1'b1;
          if (cmdLast) begin
            ctl.cntClr = 1'b1;
            nextPhase = 2'd0;
            case (cmdByte)
              CMD_READ:   nextState = ST_READ;
              CMD_MATCH:  nextState = ST_MATCH;
              CMD_SEARCH: nextState = ST_SRCH;
              CMD_ALARM:  nextState = alarmFlag ? ST_SRCH : ST_IDLE;
              CMD_SKIP: begin
                grant = 1'b1;
                nextState = ST_GRANT;
              end
              default:    nextState = ST_IDLE;
            endcase
          end else begin
            ctl.cntInc = 1'b1;
          end
        end
        ST_READ: if (txReq) begin
          if (cntLast) begin
            grant = 1'b1;
            nextState = ST_GRANT;
            ctl.cntClr = 1'b1;
          end else begin
            ctl.cntInc = 1'b1;
          end
        end
        ST_MATCH: if (rxValid) begin
          if (rxBit != idBit) begin
            nextState = ST_IDLE;
          end else if (cntLast) begin
            grant = 1'b1;
            nextState = ST_GRANT;
            ctl.cntClr = 1'b1;
          end else begin
            ctl.cntInc = 1'b1;
          end
        end
        ST_SRCH: begin
          if (phase != 2'd2) begin
            if (txReq) nextPhase = phase + 2'd1;
          end else if (rxValid) begin
            nextPhase = 2'd0;
            if (rxBit != idBit) begin
              nextState = ST_IDLE;
            end else if (cntLast) begin
              grant = 1'b1;
              nextState = ST_GRANT;
              ctl.cntClr = 1'b1;
            end else begin
              ctl.cntInc = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    txBit = 1'b1;
    if (state == ST_READ) txBit = idBit;
    else if (state == ST_SRCH && phase == 2'd0) txBit = idBit;
    else if (state == ST_SRCH && phase == 2'd1) txBit = !idBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= 2'd0;
      selected <= 1'b0;
    end else begin
      state    <= nextState;
      phase    <= nextPhase;
      selected <= grant;
    end
  end

  AST_SEL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    selected |=> !selected); // R8
  AST_SEL_AFTER_FLOW: assert property (@(posedge clk) disable iff (!rstN)
    selected |-> state == ST_GRANT && $past(state) != ST_GRANT && $past(state) != ST_IDLE); // R8
  AST_RESET_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> state == ST_CMD); // R9
  AST_MATCH_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MATCH && rxValid && rxBit != idBit && !busReset) |=> state == ST_IDLE && !selected); // R4
  AST_SEARCH_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SRCH && phase == 2'd2 && rxValid && rxBit != idBit && !busReset) |=> state == ST_IDLE); // R6
  AST_ALARM_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CMD && rxValid && cmdLast && cmdByte == CMD_ALARM && !alarmFlag && !busReset)
      |=> state == ST_IDLE); // R7
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_GRANT) |-> txBit); // R11

endmodule

// File: rtl/owRomResponder.sv
module owRomResponder
  import owRomPkg::*;
#(
  parameter int FAM_W = 8,
  parameter int SERIAL_W = 48,
  parameter int CRC_W = 8,
  parameter int CMD_W = 8,
  parameter logic [FAM_W-1:0] FAMILY = 8'h10,
  parameter logic [SERIAL_W-1:0] SERIAL = 48'hA1B2_C3D4_E5F6
) (
  input  logic clk,
  input  logic rstN,
  input  logic busReset,
  input  logic rxValid,
  input  logic rxBit,
  input  logic txReq,
  input  logic alarmFlag,
  output logic txBit,
  output logic selected
);
  dpCtl_t ctl;
  logic idBit, cntLast, cmdLast;
  logic [CMD_W-1:0] cmdByte;

  owRomDatapath #(
    .FAM_W(FAM_W), .SERIAL_W(SERIAL_W), .CRC_W(CRC_W), .CMD_W(CMD_W),
    .FAMILY(FAMILY), .SERIAL(SERIAL)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxBit(rxBit),
    .idBit(idBit), .cntLast(cntLast), .cmdLast(cmdLast), .cmdByte(cmdByte)
  );

  owRomControl #(.CMD_W(CMD_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busReset(busReset), .rxValid(rxValid),
    .rxBit(rxBit), .txReq(txReq), .alarmFlag(alarmFlag), .idBit(idBit),
    .cntLast(cntLast), .cmdLast(cmdLast), .cmdByte(cmdByte),
    .ctl(ctl), .txBit(txBit), .selected(selected)
  );

endmodule

// File: tb/owRomResponder_tb_top.sv
module owRomResponder_tb_top;
  localparam logic [7:0]  TB_FAMILY = 8'h10;
  localparam logic [47:0] TB_SERIAL = 48'h1234_5678_9ABC;

  logic clk = 0, rstN = 0, busReset = 0, rxValid = 0, rxBit = 0, txReq = 0, alarmFlag = 0;
  logic txBit, selected;
  int checks = 0, failures = 0, selCnt = 0;
  bit done = 0;
  logic [63:0] expId;

  always #10 clk = ~clk;

  owRomResponder #(.FAMILY(TB_FAMILY), .SERIAL(TB_SERIAL)) dut_i (
    .clk(clk), .rstN(rstN), .busReset(busReset), .rxValid(rxValid), .rxBit(rxBit),
    .txReq(txReq), .alarmFlag(alarmFlag), .txBit(txBit), .selected(selected)
  );

  always @(negedge clk) if (rstN && selected) selCnt++;

  function automatic logic [7:0] crcBits(input logic [63:0] v, input int n);
    logic [7:0] c = 8'h00;
    logic fb;
    for (int i = 0; i < n; i++) begin
      fb = c[0] ^ v[i];
      c = {fb, c[7:1]} ^ {4'b0000, fb, fb, 2'b00};
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseReset();
    @(negedge clk); busReset = 1;
    @(posedge clk); @(negedge clk); busReset = 0;
  endtask

  task automatic writeBit(input logic b);
    rxBit = b; rxValid = 1;
    @(posedge clk); @(negedge clk); rxValid = 0;
  endtask

  task automatic writeByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) writeBit(v[i]);
  endtask

  task automatic readBit(output logic b);
    b = txBit; txReq = 1;
    @(posedge clk); @(negedge clk); txReq = 0;
  endtask

  task automatic tResetState();
    logic b;
    int s0;
    check(txBit === 1'b1, "R11 txBit after rstN", txBit, 1);
    check(selected === 1'b0, "R8 selected after rstN", selected, 0);
    s0 = selCnt;
    writeByte(8'hCC);
    readBit(b);
    check(b === 1'b1 && selCnt == s0, "R11 silent before first bus reset", {b, 31'(selCnt - s0)}, {1'b1, 31'd0});
  endtask

  task automatic tCrc();
    check(expId[7:0] == 8'h10, "R1 family byte", expId[7:0], 8'h10);
    check(crcBits(expId, 64) == 8'h00, "R1 check residue", crcBits(expId, 64), 0);
  endtask

  task automatic tReadRom();
    logic [63:0] got;
    logic b;
    int s0;
    pulseReset();
    writeByte(8'h33);
    s0 = selCnt;
    for (int i = 0; i < 64; i++) begin
      readBit(b);
      got[i] = b;
      if (i == 62) check(selCnt == s0, "R3 no select before last bit", selCnt - s0, 0);
    end
    check(got == expId, "R3 R1 read identity", got, expId);
    check(selected === 1'b1, "R3 select after 64th slot", selected, 1);
    @(negedge clk);
    check(selected === 1'b0, "R8 one cycle pulse", selected, 0);
  endtask

  task automatic tSkip();
    pulseReset();
    writeByte(8'hCC);
    check(selected === 1'b1, "R5 skip selects", selected, 1);
    @(negedge clk);
    check(selected === 1'b0, "R8 skip pulse one cycle", selected, 0);
  endtask

  task automatic tMatch(input int badPos);
    int s0;
    logic b;
    pulseReset();
    writeByte(8'h55);
    s0 = selCnt;
    for (int i = 0; i < 64; i++) writeBit(i == badPos ? ~expId[i] : expId[i]);
    @(negedge clk);
    if (badPos < 0) begin
      check(selCnt - s0 == 1, "R4 match selects once", selCnt - s0, 1);
    end else begin
      check(selCnt == s0, "R4 mismatch never selects", selCnt - s0, 0);
      readBit(b);
      check(b === 1'b1, "R4 R11 mismatch silent", b, 1);
    end
  endtask

  task automatic tSearch(input int badPos, input bit alarmCmd);
    int s0;
    logic b, nb;
    pulseReset();
    writeByte(alarmCmd ? 8'hEC : 8'hF0);
    s0 = selCnt;
    for (int i = 0; i < 64; i++) begin
      readBit(b);
      readBit(nb);
      if (badPos >= 0 && i > badPos) begin
        check(b === 1'b1 && nb === 1'b1, "R6 dropped device released", {b, nb}, 2'b11);
      end else begin
        check(b === expId[i] && nb === ~expId[i], "R6 search bit and complement", {b, nb}, {expId[i], ~expId[i]});
      end
      writeBit(i == badPos ? ~expId[i] : expId[i]);
    end
    @(negedge clk);
    check(selCnt - s0 == (badPos < 0 ? 1 : 0), "R6 R7 search selection count", selCnt - s0, badPos < 0 ? 1 : 0);
  endtask

  task automatic tAlarmQuiet();
    logic b, nb;
    int s0;
    alarmFlag = 0;
    pulseReset();
    writeByte(8'hEC);
    s0 = selCnt;
    readBit(b);
    readBit(nb);
    check(b === 1'b1 && nb === 1'b1, "R7 no alarm stays silent", {b, nb}, 2'b11);
    writeBit(expId[0]);
    check(selCnt == s0, "R7 no alarm no select", selCnt - s0, 0);
  endtask

  task automatic tAbort();
    pulseReset();
    writeByte(8'h55);
    for (int i = 0; i < 20; i++) writeBit(expId[i]);
    pulseReset();
    writeByte(8'hCC);
    check(selected === 1'b1, "R9 reset mid match then skip", selected, 1);
    pulseReset();
    writeBit(1'b1); writeBit(1'b0); writeBit(1'b1);
    pulseReset();
    writeByte(8'hCC);
    check(selected === 1'b1, "R9 reset mid command byte", selected, 1);
  endtask

  task automatic tUnknown();
    logic b;
    int s0;
    pulseReset();
    writeByte(8'hA5);
    s0 = selCnt;
    readBit(b);
    check(b === 1'b1, "R10 unknown code silent", b, 1);
    writeByte(8'hCC);
    for (int i = 0; i < 64; i++) writeBit(expId[i]);
    check(selCnt == s0, "R10 unknown code never selects", selCnt - s0, 0);
  endtask

  task automatic tAfterGrant();
    logic b;
    int s0;
    pulseReset();
    writeByte(8'hCC);
    @(negedge clk);
    s0 = selCnt;
    readBit(b);
    check(b === 1'b1, "R11 released after grant", b, 1);
    writeByte(8'hCC);
    check(selCnt == s0, "R8 no second pulse after grant", selCnt - s0, 0);
  endtask

  initial begin
    expId = {8'h00, TB_SERIAL, TB_FAMILY};
    expId[63:56] = crcBits(expId, 56);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tResetState();
    tCrc();
    tReadRom();
    tSkip();
    tMatch(-1);
    tMatch(40);
    tMatch(0);
    tSearch(-1, 1'b0);
    tSearch(5, 1'b0);
    tAlarmQuiet();
    alarmFlag = 1;
    tSearch(-1, 1'b1);
    alarmFlag = 0;
    tAbort();
    tUnknown();
    tAfterGrant();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule